// File: doc/BRIEF.md
# Watchdog and Countdown Timer with Read-Clear Status

This block is an 8-bit down-counter that sits behind a small byte-wide register port. A set of pre-divided tick lines comes in from outside. A 3-bit source code picks one of those lines, and each pulse on the chosen line moves the counter down by one. A 2-bit mode field places the timer in one of three functions: disabled, a free-running countdown that reloads itself on every expiry, or a one-shot watchdog that stops at zero. When an expiry happens, the matching status flag in the status register is set. An enabled flag can drive the interrupt output, either as a steady level or as a fixed-width pulse.

Software services the watchdog flag by reading the status register. That read returns the flag and clears it in the same access. The countdown flag is cleared by writing a zero into its bit. Writing the timer value reloads the counter straight away, and reading that same address returns the count still remaining.

The control state machine has four states. Idle holds the count. Countdown-run decrements and reloads. Watchdog-run decrements toward zero. Watchdog-halted parks at zero after an expiry. Every state moves to the state that the mode field names, one clock after a mode write: code 01 selects countdown-run, code 10 selects watchdog-run, and any other code selects idle. Watchdog-run moves to watchdog-halted on expiry. Watchdog-halted returns to watchdog-run when the timer value is written. A second state machine, with states Quiet and High, shapes the pulsed interrupt. An enabled expiry moves it from Quiet to High. It moves from High back to Quiet once its cycle counter runs out, and a new enabled expiry while it is High restarts that counter.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads as 0x00, cfg_rdata is 0x00 and irq is low.
- R2: Mode field bits 2:1 of address 0x0F: 01 = countdown, 10 = watchdog. With 00 or 11 the counter ignores ticks, and the value read from 0x11 does not change.
- R3: Bits 2:0 of address 0x10 pick which src_ticks line is counted; code 010 selects line 2. Pulses on the other lines have no effect on the count.
- R4: A write to 0x11 loads the counter with the written byte. A read of 0x11 returns the remaining count. Each selected tick in a running mode lowers the count by one.
- R5: In watchdog mode, the tick that brings the count from 1 to 0 sets bit 7 of 0x01. The counter then stays at 0 until 0x11 is written again.
- R6: In countdown mode, the tick that brings the count from 1 to 0 sets bit 6 of 0x01 and reloads the last value written to 0x11, and counting continues.
- R7: Bit 7 of 0x01 cannot be written. A read of 0x01 returns its value and clears it.
- R8: If a read of 0x01 and a watchdog expiry fall in the same cycle, bit 7 remains set.
- R9: Bit 6 of 0x01 is cleared only by writing 0 to it. Writing 1 to it, or reading it, leaves it unchanged.
- R10: Bit 2 of 0x01 enables the watchdog interrupt and bit 1 enables the countdown interrupt. With bit 7 of 0x0F at 0, irq is high exactly while some flag and its enable are both set.
- R11: With bit 7 of 0x0F at 1, an enabled expiry drives irq high for exactly 4 clock cycles, starting at the clock edge that samples the expiring tick. A disabled expiry gives no pulse.
- R12: If a write to 0x11 coincides with a selected tick, the written value is loaded and the tick is dropped.
- R13: Read data appears on cfg_rdata one clock after cfg_re and holds until the next read. A flag set by a tick is visible from the clock edge that samples that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| src_ticks | input | SRC_NUM (8) | Single-cycle tick pulses, one per source rate |
| irq | output | 1 | Interrupt, level or pulsed |

## Verification
The hardest case to reach from the ports is a status read that lands in the very cycle in which a watchdog expiry sets the flag. In that cycle the clear caused by the read and the set caused by the expiry compete. The stimulus first loads the counter with 1 in watchdog mode. It then raises the read strobe for address 0x01 and the selected tick line together, for one cycle. Two follow-up reads show that the flag survived the collision and that it is cleared afterwards. The same approach drives a timer-value write on the same cycle as a tick, to show that the load takes priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register map; the bench and software both depend on these positions.
    localparam logic [7:0] A_FLAGS = 8'h01;
    localparam logic [7:0] A_CTRL  = 8'h0F;
    localparam logic [7:0] A_SRC   = 8'h10;
    localparam logic [7:0] A_LOAD  = 8'h11;

    localparam int B_WD_FLAG = 7;
    localparam int B_CD_FLAG = 6;
    localparam int B_WD_IE   = 2;
    localparam int B_CD_IE   = 1;
    localparam int B_PULSE   = 7;
    localparam int B_MODE_LO = 1;

    // Width of the source select code
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        M_OFF_A = 2'b00,
        M_COUNT = 2'b01,
        M_WATCH = 2'b10,
        M_OFF_B = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CD_RUN,
        S_WD_RUN,
        S_WD_HALT
    } core_st_e;

    typedef enum logic {
        P_QUIET,
        P_HIGH
    } pulse_st_e;

    // State a mode code leads to
    function automatic core_st_e mode_entry(input tmode_e m);
        case (m)
            M_COUNT: return S_CD_RUN;
            M_WATCH: return S_WD_RUN;
            default: return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             re,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [CNT_W-1:0] count,
    input  logic             wd_expire,
    input  logic             cd_expire,
    output tmode_e           mode,
    output logic             pulse_mode,
    output logic [SEL_W-1:0] src_sel,
    output logic [CNT_W-1:0] reload,
    output logic             load_strobe,
    output logic             wd_ie,
    output logic             cd_ie,
    output logic             wd_flag,
    output logic             cd_flag
);

    logic       wr_flags;
    logic       rd_flags;
    logic [7:0] rd_mux;

    assign wr_flags    = we && (addr == A_FLAGS);
    assign rd_flags    = re && (addr == A_FLAGS);
    assign load_strobe = we && (addr == A_LOAD);

    // Configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= M_OFF_A;
            pulse_mode <= 1'b0;
            src_sel    <= '0;
            reload     <= '0;
            wd_ie      <= 1'b0;
            cd_ie      <= 1'b0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    pulse_mode <= wdata[B_PULSE];
                    mode       <= tmode_e'(wdata[B_MODE_LO +: 2]);
                end
                A_SRC:   src_sel <= wdata[SEL_W-1:0];
                A_LOAD:  reload  <= wdata[CNT_W-1:0];
                A_FLAGS: begin
                    wd_ie <= wdata[B_WD_IE];
                    cd_ie <= wdata[B_CD_IE];
                end
                default: ;
            endcase
        end
    end

    // Status flags: a set always beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
            cd_flag <= 1'b0;
        end else begin
            if (wd_expire)
                wd_flag <= 1'b1;
            else if (rd_flags)
                wd_flag <= 1'b0;

            if (cd_expire)
                cd_flag <= 1'b1;
            else if (wr_flags && !wdata[B_CD_FLAG])
                cd_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_FLAGS: begin
                rd_mux[B_WD_FLAG] = wd_flag;
                rd_mux[B_CD_FLAG] = cd_flag;
                rd_mux[B_WD_IE]   = wd_ie;
                rd_mux[B_CD_IE]   = cd_ie;
            end
            A_CTRL: begin
                rd_mux[B_PULSE]         = pulse_mode;
                rd_mux[B_MODE_LO +: 2]  = mode;
            end
            A_SRC:   rd_mux[SEL_W-1:0] = src_sel;
            A_LOAD:  rd_mux[CNT_W-1:0] = count;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= rd_mux;
    end

    p_wd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> wd_flag);

    p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !wd_expire) |=> !wd_flag);

    p_no_write_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && !wd_expire) |=> !wd_flag);

    p_collision_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && wd_expire) |=> wd_flag);

    p_cd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flag && !(wr_flags && !wdata[B_CD_FLAG])) |=> cd_flag);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SRC_NUM = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tmode_e             mode,
    input  logic [SRC_NUM-1:0] src_ticks,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [CNT_W-1:0]   reload,
    input  logic               load_strobe,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic               wd_expire,
    output logic               cd_expire
);

    localparam int LINES = 1 << SEL_W;

    logic [LINES-1:0] line_vec;
    core_st_e         state;
    core_st_e         state_nx;
    logic             step;
    logic             at_one;

    // Unused select codes read as a line that never ticks
    generate
        if (SRC_NUM < LINES) begin : g_pad
            assign line_vec = {{(LINES - SRC_NUM){1'b0}}, src_ticks};
        end else begin : g_full
            assign line_vec = src_ticks[LINES-1:0];
        end
    endgenerate

    assign step   = line_vec[src_sel] && !load_strobe;
    assign at_one = (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_CD_RUN: state_nx = mode_entry(mode);
            S_WD_RUN: begin
                if (mode != M_WATCH)
                    state_nx = mode_entry(mode);
                else if (wd_expire)
                    state_nx = S_WD_HALT;
            end
            S_WD_HALT: begin
                if (mode != M_WATCH)
                    state_nx = mode_entry(mode);
                else if (load_strobe)
                    state_nx = S_WD_RUN;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        wd_expire = (state == S_WD_RUN) && step && at_one;
        cd_expire = (state == S_CD_RUN) && step && at_one;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_strobe) begin
            count <= load_val;
        end else if (step) begin
            case (state)
                S_CD_RUN:
                    count <= (count <= CNT_W'(1)) ? reload : count - 1'b1;
                S_WD_RUN:
                    if (count != '0)
                        count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    p_halt_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WD_HALT) |-> (count == '0));

    p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> (count == $past(load_val)));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !load_strobe) |=> $stable(count));

    p_one_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wd_expire, cd_expire}));

endmodule

// File: rtl/wdog_irq.sv
module wdog_irq
    import wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode,
    input  logic wd_flag,
    input  logic cd_flag,
    input  logic wd_ie,
    input  logic cd_ie,
    input  logic wd_expire,
    input  logic cd_expire,
    output logic irq
);

    localparam int LEFT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(PULSE_CYCLES - 1);

    pulse_st_e         pst;
    pulse_st_e         pst_nx;
    logic [LEFT_W-1:0] left;
    logic [LEFT_W-1:0] left_nx;
    logic              fire;
    logic              level;

    assign fire = pulse_mode && ((wd_expire && wd_ie) || (cd_expire && cd_ie));

    always_comb begin
        pst_nx  = pst;
        left_nx = left;
        unique case (pst)
            P_QUIET: begin
                if (fire) begin
                    pst_nx  = P_HIGH;
                    left_nx = LEFT_INIT;
                end
            end
            P_HIGH: begin
                if (fire)
                    left_nx = LEFT_INIT;
                else if (left == '0)
                    pst_nx = P_QUIET;
                else
                    left_nx = left - 1'b1;
            end
            default: pst_nx = P_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst  <= P_QUIET;
            left <= '0;
        end else begin
            pst  <= pst_nx;
            left <= left_nx;
        end
    end

    always_comb begin
        level = (wd_flag && wd_ie) || (cd_flag && cd_ie);
        irq   = pulse_mode ? (pst == P_HIGH) : level;
    end

    p_pulse_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pst == P_HIGH));

    p_pulse_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pst == P_HIGH && left == '0 && !fire) |=> (pst == P_QUIET));

    p_level_wd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && wd_flag && wd_ie) |-> irq);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int SRC_NUM      = 8,
    parameter int CNT_W        = 8,
    parameter int PULSE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_re,
    input  logic [7:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [SRC_NUM-1:0] src_ticks,
    output logic               irq
);

    tmode_e           mode;
    logic             pulse_mode;
    logic [SEL_W-1:0] src_sel;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             load_strobe;
    logic             wd_ie;
    logic             cd_ie;
    logic             wd_flag;
    logic             cd_flag;
    logic             wd_expire;
    logic             cd_expire;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .re          (cfg_re),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .count       (count),
        .wd_expire   (wd_expire),
        .cd_expire   (cd_expire),
        .mode        (mode),
        .pulse_mode  (pulse_mode),
        .src_sel     (src_sel),
        .reload      (reload),
        .load_strobe (load_strobe),
        .wd_ie       (wd_ie),
        .cd_ie       (cd_ie),
        .wd_flag     (wd_flag),
        .cd_flag     (cd_flag)
    );

    wdog_core #(.CNT_W(CNT_W), .SRC_NUM(SRC_NUM)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .src_ticks   (src_ticks),
        .src_sel     (src_sel),
        .reload      (reload),
        .load_strobe (load_strobe),
        .load_val    (cfg_wdata[CNT_W-1:0]),
        .count       (count),
        .wd_expire   (wd_expire),
        .cd_expire   (cd_expire)
    );

    wdog_irq #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (pulse_mode),
        .wd_flag    (wd_flag),
        .cd_flag    (cd_flag),
        .wd_ie      (wd_ie),
        .cd_ie      (cd_ie),
        .wd_expire  (wd_expire),
        .cd_expire  (cd_expire),
        .irq        (irq)
    );

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_re = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [7:0] src_ticks = 8'h00;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_ticks (src_ticks),
        .irq       (irq)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: each read strobe seen at an edge yields one result just after it (R13)
    always begin : monitor
        logic       took;
        logic [7:0] e;
        string      t;
        @(posedge clk);
        took = cfg_re;
        #1;
        if (took) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R13 unexpected read result actual=%02h expected=none", cfg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (cfg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%02h expected=%02h", t, cfg_rdata, e);
                end
            end
        end
    end

    task automatic push_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        cfg_re = 1'b1; cfg_addr = a;
        push_exp(e, t);
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    task automatic tick(input int line);
        @(negedge clk);
        src_ticks[line] = 1'b1;
        @(negedge clk);
        src_ticks = 8'h00;
    endtask

    task automatic check_irq(input logic e, input string t);
        n_vec++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic pulse_seq(input string t);
        check_irq(1'b1, t);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_irq(1'b1, t);
        end
        @(negedge clk);
        check_irq(1'b0, t);
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        n_vec++;
        if (cfg_rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 rdata actual=%02h expected=00", cfg_rdata);
        end
        check_irq(1'b0, "R1 irq after reset");
        rd(8'h01, 8'h00, "R1 flags reset");
        rd(8'h0F, 8'h00, "R1 ctrl reset");
        rd(8'h10, 8'h00, "R1 source reset");
        rd(8'h11, 8'h00, "R1 count reset");

        // R2 disabled modes ignore ticks
        wr(8'h10, 8'h02);
        wr(8'h11, 8'h05);
        wr(8'h0F, 8'h00);
        repeat (3) tick(2);
        rd(8'h11, 8'h05, "R2 mode 00 holds");
        wr(8'h0F, 8'h06);
        repeat (2) tick(2);
        rd(8'h11, 8'h05, "R2 mode 11 holds");
        rd(8'h0F, 8'h06, "R2 ctrl readback");

        // R3 source selection, R4 decrement
        wr(8'h0F, 8'h04);
        tick(0);
        tick(7);
        rd(8'h11, 8'h05, "R3 other lines ignored");
        tick(2);
        rd(8'h11, 8'h04, "R4 selected line decrements");
        wr(8'h10, 8'h05);
        tick(2);
        rd(8'h11, 8'h04, "R3 old line ignored after reselect");
        tick(5);
        rd(8'h11, 8'h03, "R3 new line counts");
        rd(8'h10, 8'h05, "R3 source readback");

        // R5 watchdog expiry and halt, R10 level irq
        wr(8'h10, 8'h02);
        wr(8'h01, 8'h04);
        wr(8'h11, 8'h03);
        tick(2);
        tick(2);
        rd(8'h11, 8'h01, "R4 count after two ticks");
        check_irq(1'b0, "R10 no flag no irq");
        tick(2);
        check_irq(1'b1, "R10 level irq on watchdog flag");
        rd(8'h11, 8'h00, "R5 count at zero");
        tick(2);
        tick(2);
        rd(8'h11, 8'h00, "R5 halted at zero");
        rd(8'h01, 8'h84, "R5 watchdog flag set");
        check_irq(1'b0, "R7 irq drops after clearing read");
        rd(8'h01, 8'h04, "R7 read cleared flag");

        // R7 write cannot set or clear the watchdog flag
        wr(8'h01, 8'h84);
        rd(8'h01, 8'h04, "R7 write one ignored");
        wr(8'h11, 8'h01);
        tick(2);
        wr(8'h01, 8'h04);
        rd(8'h01, 8'h84, "R7 write zero ignored");
        rd(8'h01, 8'h04, "R7 cleared by read");

        // R8 read and expiry in the same cycle
        wr(8'h11, 8'h01);
        @(negedge clk);
        cfg_re = 1'b1; cfg_addr = 8'h01; src_ticks = 8'h04;
        push_exp(8'h04, "R8 value sampled before expiry");
        @(negedge clk);
        cfg_re = 1'b0; src_ticks = 8'h00;
        rd(8'h01, 8'h84, "R8 flag kept after collision");
        rd(8'h01, 8'h04, "R8 next read clears");

        // R12 load and tick in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h11; cfg_wdata = 8'h09; src_ticks = 8'h04;
        @(negedge clk);
        cfg_we = 1'b0; src_ticks = 8'h00;
        rd(8'h11, 8'h09, "R12 load wins over tick");
        tick(2);
        rd(8'h11, 8'h08, "R4 count after reload");

        // R6 countdown with reload, R9 flag clearing by write
        wr(8'h0F, 8'h02);
        wr(8'h01, 8'h02);
        wr(8'h11, 8'h03);
        repeat (3) tick(2);
        check_irq(1'b1, "R10 level irq on countdown flag");
        rd(8'h01, 8'h42, "R6 countdown flag set");
        rd(8'h11, 8'h03, "R6 reloaded value");
        rd(8'h01, 8'h42, "R9 read keeps countdown flag");
        wr(8'h01, 8'h42);
        rd(8'h01, 8'h42, "R9 write one keeps flag");
        wr(8'h01, 8'h02);
        rd(8'h01, 8'h02, "R9 write zero clears flag");
        check_irq(1'b0, "R10 irq low after clear");
        repeat (2) tick(2);
        rd(8'h11, 8'h01, "R6 counting continues");
        tick(2);
        rd(8'h01, 8'h42, "R6 second expiry");

        // R10 enable off masks level irq
        wr(8'h01, 8'h40);
        check_irq(1'b0, "R10 enable off masks flag");
        rd(8'h01, 8'h40, "R10 flag still set");

        // R11 pulsed output, countdown
        wr(8'h01, 8'h02);
        wr(8'h0F, 8'h82);
        repeat (2) tick(2);
        tick(2);
        pulse_seq("R11 countdown pulse width");
        @(negedge clk);
        check_irq(1'b0, "R11 stays low after pulse");
        rd(8'h01, 8'h42, "R11 flag set in pulsed mode");

        // R11 disabled expiry gives no pulse
        wr(8'h01, 8'h00);
        repeat (3) tick(2);
        check_irq(1'b0, "R11 disabled no pulse");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_irq(1'b0, "R11 disabled no pulse");
        end
        rd(8'h01, 8'h40, "R11 flag set without pulse");

        // R11 pulsed output, watchdog
        wr(8'h0F, 8'h84);
        wr(8'h01, 8'h04);
        wr(8'h11, 8'h02);
        tick(2);
        tick(2);
        pulse_seq("R11 watchdog pulse width");
        rd(8'h01, 8'h84, "R11 watchdog flag in pulsed mode");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R13 reads without result actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule